// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the power modes of a small microcontroller subsystem. A strobe from the CPU's sleep instruction moves the controller out of normal operation into one of two low-power states, depending on a standby-select bit. In light sleep the clock generator keeps running and only the CPU clock and the debug break unit stop. In deep standby the clock generator, the CPU and every on-chip peripheral halt, and external memory is switched from auto-refresh to self-refresh. An interrupt request or a reset cancels either state.

Independently of the CPU mode, four module-stop registers gate the clock of individual peripherals. Writing a 1 to an ordinary stop bit stops its module. Writing a 1 to a bit of the USB group restarts that module. On leaving standby, the clock generator is re-enabled first and the CPU clock follows only after a programmable number of settle cycles.

The state machine has four states. RUN is the normal state. SLEEP is light sleep. STANDBY is deep standby. SETTLE is the clock-settling period after standby. The transitions are:
- RUN to SLEEP on a strobe with standby-select 0.
- RUN to STANDBY on a strobe with standby-select 1.
- SLEEP to RUN on an interrupt.
- STANDBY to SETTLE on an interrupt.
- SETTLE to RUN when the settle count is reached.
- Any state to RUN on reset.

Top module: `lpm_ctrl`

## Requirements
- R1: In RUN, a `slp_stb` pulse with `stby_sel`=0 moves the controller to SLEEP on the next clock edge. SLEEP is reported as `mode_o`=01 and has `cpu_clk_en`=0 and `cpg_en`=1.
- R2: In SLEEP, `dbg_en`=0 and `self_refresh`=0 (auto-refresh). Every peripheral whose stop bit holds its run value keeps `periph_en` high.
- R3: In RUN, a `slp_stb` pulse with `stby_sel`=1 moves the controller to STANDBY on the next edge. STANDBY is reported as `mode_o`=10 and has `cpg_en`=0, `cpu_clk_en`=0, `dbg_en`=0, `periph_en`=0 and `self_refresh`=1.
- R4: `irq` high at an edge in SLEEP returns the controller to RUN (`mode_o`=00, all clocks on, `self_refresh`=0). `irq` high at an edge in STANDBY enters SETTLE.
- R5: `stop_wr[k]` high at an edge loads `stop_wdata` into stop bits 8k+7..8k. Module i is stopped (`periph_en[i]`=0) when an ordinary bit i is 1, while `cpu_clk_en` and `cpg_en` stay 1. Registers not written keep their value.
- R6: Stop bits marked in `USB_MASK` (default bits 9:8, i.e. bits 1:0 of register 1) have inverted polarity: 0 stops the module and 1 runs it.
- R7: Reset gives RUN and sets every stop bit to its run value: 0 for ordinary bits and 1 for USB bits. All `periph_en` bits become 1 and the settle count becomes 16.
- R8: In SETTLE, `mode_o` reads 10, `cpg_en`=1, `cpu_clk_en`=0, `periph_en`=0 and `self_refresh`=1. After `cpg_en` has been high for N cycles, the controller returns to RUN. N is the value last written through `settle_wr`/`settle_wdata`; a written 0 counts as 1.
- R9: A `slp_stb` pulse in SLEEP, STANDBY or SETTLE is ignored and the state is unchanged.
- R10: `rst_n` low forces RUN asynchronously, cancelling SLEEP or STANDBY without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| slp_stb | input | 1 | One-cycle strobe from the sleep instruction |
| stby_sel | input | 1 | Low-power target select: 0 sleep, 1 standby |
| irq | input | 1 | Interrupt request, wakes from low power |
| stop_wr | input | 4 | Per-register write enables for the stop registers |
| stop_wdata | input | 8 | Write data for the stop registers |
| settle_wr | input | 1 | Write enable for the settle count |
| settle_wdata | input | 8 | Settle count in cycles |
| mode_o | output | 2 | Reported mode: 00 run, 01 sleep, 10 standby/settle |
| cpg_en | output | 1 | Clock-generator run enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| dbg_en | output | 1 | Debug break unit enable |
| self_refresh | output | 1 | External memory refresh: 0 auto, 1 self |
| periph_en | output | 32 | Per-peripheral clock enables |

## Verification
The assertions assume that the settle count is not rewritten while the controller is in SETTLE. They also assume that `slp_stb` and `irq` are never high in the same cycle in RUN. The stimulus raises `irq` only in a low-power state and writes the settle count only in RUN, so both assumptions always hold. Strobes sent to ignored states are one-cycle pulses with `irq` low, which keeps the stay-in-state properties meaningful.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_SLEEP  = 2'b01,
        ST_STBY   = 2'b10,
        ST_SETTLE = 2'b11
    } lpm_state_t;

    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_SLEEP = 2'b01;
    localparam logic [1:0] MODE_STBY  = 2'b10;
endpackage

// File: rtl/lpm_stop_bank.sv
module lpm_stop_bank #(
    parameter int          NUM_REGS = 4,
    parameter int          REG_W    = 8,
    parameter logic [NUM_REGS*REG_W-1:0] INV_MASK = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REGS-1:0]       wr,
    input  logic [REG_W-1:0]          wdata,
    output logic [NUM_REGS*REG_W-1:0] running
);
    localparam int TOT_W = NUM_REGS * REG_W;

    logic [TOT_W-1:0] stop_q;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam int LO = k * REG_W;

        // reset loads the run value: 0 for ordinary bits, 1 for inverted bits
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stop_q[LO +: REG_W] <= INV_MASK[LO +: REG_W];
            end else if (wr[k]) begin
                stop_q[LO +: REG_W] <= wdata;
            end
        end

        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !wr[k] |=> $stable(stop_q[LO +: REG_W]));

        assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr[k] |=> stop_q[LO +: REG_W] == $past(wdata));
    end

    // a module runs when its bit differs from the polarity that stops it
    assign running = ~(stop_q ^ INV_MASK);
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SETTLE_DEF = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slp_stb,
    input  logic             stby_sel,
    input  logic             irq,
    input  logic             settle_wr,
    input  logic [CNT_W-1:0] settle_wdata,
    output logic [1:0]       mode_o,
    output logic             cpg_en,
    output logic             cpu_clk_en,
    output logic             dbg_en,
    output logic             self_refresh,
    output logic             periph_gate
);
    localparam logic [CNT_W-1:0] SETTLE_RST = CNT_W'(SETTLE_DEF);

    lpm_state_t       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] settle_q;
    logic [CNT_W:0]   settle_eff;
    logic [CNT_W:0]   cnt_inc;
    logic             settle_done;

    assign settle_eff  = (settle_q == '0) ? (CNT_W+1)'(1) : {1'b0, settle_q};
    assign cnt_inc     = {1'b0, cnt} + (CNT_W+1)'(1);
    assign settle_done = (cnt_inc >= settle_eff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= SETTLE_RST;
        end else if (settle_wr) begin
            settle_q <= settle_wdata;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (slp_stb) nxt = stby_sel ? ST_STBY : ST_SLEEP;
            end
            ST_SLEEP: begin
                if (irq) nxt = ST_RUN;
            end
            ST_STBY: begin
                if (irq) nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_done) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_SETTLE) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        mode_o       = MODE_RUN;
        cpg_en       = 1'b1;
        cpu_clk_en   = 1'b1;
        dbg_en       = 1'b1;
        self_refresh = 1'b0;
        periph_gate  = 1'b1;
        unique case (state)
            ST_RUN: begin
                mode_o = MODE_RUN;
            end
            ST_SLEEP: begin
                mode_o     = MODE_SLEEP;
                cpu_clk_en = 1'b0;
                dbg_en     = 1'b0;
            end
            ST_STBY: begin
                mode_o       = MODE_STBY;
                cpg_en       = 1'b0;
                cpu_clk_en   = 1'b0;
                dbg_en       = 1'b0;
                self_refresh = 1'b1;
                periph_gate  = 1'b0;
            end
            ST_SETTLE: begin
                mode_o       = MODE_STBY;
                cpu_clk_en   = 1'b0;
                dbg_en       = 1'b0;
                self_refresh = 1'b1;
                periph_gate  = 1'b0;
            end
            default: begin
                mode_o = MODE_RUN;
            end
        endcase
    end

    assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && slp_stb && !stby_sel) |=> state == ST_SLEEP);

    assert_stby_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && slp_stb && stby_sel) |=> state == ST_STBY);

    assert_sleep_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && irq) |=> state == ST_RUN);

    assert_stby_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && irq) |=> state == ST_SETTLE);

    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !irq) |=> state == ST_SLEEP);

    assert_stby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STBY && !irq) |=> state == ST_STBY);

    assert_settle_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !settle_done && !settle_wr) |=> state == ST_SETTLE);

    assert_settle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !settle_done) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NUM_REGS   = 4,
    parameter int REG_W      = 8,
    parameter int CNT_W      = 8,
    parameter int SETTLE_DEF = 16,
    parameter logic [NUM_REGS*REG_W-1:0] USB_MASK = 32'h0000_0300
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      slp_stb,
    input  logic                      stby_sel,
    input  logic                      irq,
    input  logic [NUM_REGS-1:0]       stop_wr,
    input  logic [REG_W-1:0]          stop_wdata,
    input  logic                      settle_wr,
    input  logic [CNT_W-1:0]          settle_wdata,
    output logic [1:0]                mode_o,
    output logic                      cpg_en,
    output logic                      cpu_clk_en,
    output logic                      dbg_en,
    output logic                      self_refresh,
    output logic [NUM_REGS*REG_W-1:0] periph_en
);
    localparam int TOT_W = NUM_REGS * REG_W;

    logic [TOT_W-1:0] running;
    logic             periph_gate;

    lpm_seq #(
        .CNT_W      (CNT_W),
        .SETTLE_DEF (SETTLE_DEF)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .slp_stb      (slp_stb),
        .stby_sel     (stby_sel),
        .irq          (irq),
        .settle_wr    (settle_wr),
        .settle_wdata (settle_wdata),
        .mode_o       (mode_o),
        .cpg_en       (cpg_en),
        .cpu_clk_en   (cpu_clk_en),
        .dbg_en       (dbg_en),
        .self_refresh (self_refresh),
        .periph_gate  (periph_gate)
    );

    lpm_stop_bank #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .INV_MASK (USB_MASK)
    ) u_stop (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (stop_wr),
        .wdata   (stop_wdata),
        .running (running)
    );

    assign periph_en = periph_gate ? running : '0;

    assert_stby_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STBY) |-> (periph_en == '0 && self_refresh && !cpu_clk_en));

    assert_sleep_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP) |-> (cpg_en && !self_refresh && periph_en == running));

    assert_cpu_needs_cpg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> cpg_en);
endmodule

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slp_stb = 1'b0, stby_sel = 1'b0, irq = 1'b0, settle_wr = 1'b0;
    logic [3:0]  stop_wr = '0;
    logic [7:0]  stop_wdata = '0, settle_wdata = '0;
    logic [1:0]  mode_o;
    logic        cpg_en, cpu_clk_en, dbg_en, self_refresh;
    logic [31:0] periph_en;

    always #2 clk = ~clk;

    lpm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .slp_stb(slp_stb), .stby_sel(stby_sel), .irq(irq),
        .stop_wr(stop_wr), .stop_wdata(stop_wdata), .settle_wr(settle_wr),
        .settle_wdata(settle_wdata), .mode_o(mode_o), .cpg_en(cpg_en),
        .cpu_clk_en(cpu_clk_en), .dbg_en(dbg_en), .self_refresh(self_refresh),
        .periph_en(periph_en)
    );

    // expected vector: mode(2) cpg cpu dbg sref periph(32)
    typedef logic [37:0] exp_t;
    exp_t  q_exp[$];
    string q_tag[$];
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;

    function automatic exp_t mk(logic [1:0] m, logic g, logic c, logic d, logic s, logic [31:0] p);
        return {m, g, c, d, s, p};
    endfunction

    localparam exp_t RUN_ALL = 38'h0; // placeholder not used

    task automatic compare(exp_t e, string tag);
        exp_t a;
        a = {mode_o, cpg_en, cpu_clk_en, dbg_en, self_refresh, periph_en};
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual mode=%b cpg=%b cpu=%b dbg=%b sref=%b periph=%h expected mode=%b cpg=%b cpu=%b dbg=%b sref=%b periph=%h",
                     tag, a[37:36], a[35], a[34], a[33], a[32], a[31:0],
                     e[37:36], e[35], e[34], e[33], e[32], e[31:0]);
        end
    endtask

    // monitor: compares each queued expectation after the edge that produced it
    initial begin
        forever begin
            @(negedge clk);
            while (q_exp.size() > 0) begin
                exp_t  e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                compare(e, t);
            end
        end
    end

    // driver: apply inputs for one cycle and push what the next edge must give
    task automatic step(logic stb, logic sel, logic ir, logic [3:0] swr, logic [7:0] sd,
                        logic stw, logic [7:0] stv, exp_t e, string tag);
        @(negedge clk);
        slp_stb = stb; stby_sel = sel; irq = ir; stop_wr = swr; stop_wdata = sd;
        settle_wr = stw; settle_wdata = stv;
        @(posedge clk);
        #1;
        slp_stb = 0; irq = 0; stop_wr = '0; settle_wr = 0;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    function automatic exp_t run_e(logic [31:0] p);  return mk(2'b00, 1, 1, 1, 0, p); endfunction
    function automatic exp_t slp_e(logic [31:0] p);  return mk(2'b01, 1, 0, 0, 0, p); endfunction
    function automatic exp_t stby_e();               return mk(2'b10, 0, 0, 0, 1, 32'h0); endfunction
    function automatic exp_t setl_e();               return mk(2'b10, 1, 0, 0, 1, 32'h0); endfunction

    initial begin
        #10000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1 compare(run_e(32'hFFFF_FFFF), "R7 reset state");

        // R5: ordinary stop bits 0 and 2 of register 0
        step(0,0,0,4'b0001,8'h05,0,0, run_e(32'hFFFF_FFFA), "R5 stop reg0 bits");
        // R6: clearing USB bits stops those modules, setting restarts
        step(0,0,0,4'b0010,8'h00,0,0, run_e(32'hFFFF_FCFA), "R6 usb cleared stops");
        step(0,0,0,4'b0010,8'h03,0,0, run_e(32'hFFFF_FFFA), "R6 usb set runs");
        step(0,0,0,4'b1000,8'h80,0,0, run_e(32'h7FFF_FFFA), "R5 stop reg3 bit7");
        step(0,0,0,4'b1000,8'h00,0,0, run_e(32'hFFFF_FFFA), "R5 reg3 restored");

        // R1/R2 sleep entry and behaviour
        step(1,0,0,0,0,0,0, slp_e(32'hFFFF_FFFA), "R1 sleep entry");
        step(0,0,0,0,0,0,0, slp_e(32'hFFFF_FFFA), "R2 sleep held");
        step(1,1,0,0,0,0,0, slp_e(32'hFFFF_FFFA), "R9 strobe in sleep ignored");
        step(0,0,1,0,0,0,0, run_e(32'hFFFF_FFFA), "R4 irq leaves sleep");

        // R3 standby with 4-cycle settle
        step(0,0,0,0,0,1,8'd4, run_e(32'hFFFF_FFFA), "R8 settle write");
        step(1,1,0,0,0,0,0, stby_e(), "R3 standby entry");
        step(1,0,0,0,0,0,0, stby_e(), "R9 strobe in standby ignored");
        step(0,0,0,0,0,0,0, stby_e(), "R3 standby held");
        step(0,0,1,0,0,0,0, setl_e(), "R4 irq enters settle");
        step(1,0,0,0,0,0,0, setl_e(), "R9 strobe in settle ignored");
        step(0,0,0,0,0,0,0, setl_e(), "R8 settle cycle 3");
        step(0,0,0,0,0,0,0, setl_e(), "R8 settle cycle 4");
        step(0,0,0,0,0,0,0, run_e(32'hFFFF_FFFA), "R8 cpu after settle");

        // R10 asynchronous reset cancels sleep, R7 restores stop bits and settle
        step(1,0,0,0,0,0,0, slp_e(32'hFFFF_FFFA), "R1 sleep again");
        @(negedge clk);
        #1 rst_n = 0;
        #0.5 compare(run_e(32'hFFFF_FFFF), "R10 async reset cancels sleep");
        @(negedge clk) rst_n = 1;

        // R7 default settle of 16 cycles
        step(1,1,0,0,0,0,0, stby_e(), "R3 standby after reset");
        step(0,0,1,0,0,0,0, setl_e(), "R4 irq enters settle default");
        for (int i = 2; i <= 16; i++)
            step(0,0,0,0,0,0,0, setl_e(), "R7 default settle");
        step(0,0,0,0,0,0,0, run_e(32'hFFFF_FFFF), "R7 run after 16 settle cycles");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule